// File: doc/BRIEF.md
# Variable-Frequency Phase-Step Rate Generator

This block is a numerically controlled oscillator that derives a slower time base from a fixed reference clock. A 16-bit tuning word, loaded by software as two byte-wide halves, sets a phase step. A 16-bit phase accumulator advances by that step on every reference cycle while the channel runs. The top bit of the accumulator is the square-wave output. A one-cycle tick marks each rising edge of the square wave and serves as the clock-enable for a downstream constant-frequency PWM stage.

The step is the tuning word itself when the word is below 0x8000. At or above 0x8000 the step is the word's 16-bit two's complement. The output rate is therefore step / 65536 times the reference rate. Only power-of-two steps give a square wave whose high and low halves are exactly equal.

The high byte goes to a staging register and has no effect by itself. A low-byte write commits the staged high byte and the new low byte together, so the accumulator never adds a half-updated step. A two-state run controller (STOPPED, RUNNING) follows the start enable:
- Transition START moves STOPPED to RUNNING when the enable is seen high.
- Transition HALT moves RUNNING to STOPPED when the enable is seen low.

While STOPPED, the accumulator is held at zero.

Top module: `nco_rategen`

## Requirements
- R1: During and after reset the outputs `sq_out` and `tick_out` are 0, the committed tuning word is 0x0000, the staged high byte is 0x00, and the controller is STOPPED.
- R2: A write on `wr_hi` alone changes only the staging register. The step in use, and so the output sequence, stays the same.
- R3: A write on `wr_lo` commits the word {staged high byte, `wr_data`}. The staged high byte occupies bits 15:8 and `wr_data` occupies bits 7:0. If `wr_hi` and `wr_lo` are both high in one cycle, the commit uses the high byte staged before that cycle. The new step is first added on the clock edge after the commit edge.
- R4: The step W equals the word when the word is below 0x8000, and equals 65536 minus the word otherwise. For example, 0x8000 gives 0x8000 and 0xFFFF gives 1.
- R5: On each clock edge where the controller is RUNNING and `run_en` is high, the accumulator gains W modulo 65536. `sq_out` is bit 15 of the accumulator.
- R6: `tick_out` is high for exactly the cycles in which `sq_out` has just changed from 0 to 1.
- R7: If `run_en` is low at an edge, the accumulator is cleared and the controller goes to STOPPED, so there are no ticks. The first edge that sees `run_en` high only performs START. Accumulation begins on the following edge, starting from zero.
- R8: For W = 2^k (k = 1..15) the output period is 2^(16-k) cycles. The output is high for exactly half of each period and carries one tick per period.
- R9: A step of zero (word 0x0000) keeps `sq_out` low with no ticks while the channel runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Byte written to either half of the tuning word |
| wr_hi | input | 1 | Write strobe: stage the high byte |
| wr_lo | input | 1 | Write strobe: low byte, commits the whole word |
| run_en | input | 1 | Channel start enable |
| sq_out | output | 1 | Square-wave level (accumulator MSB) |
| tick_out | output | 1 | One-cycle pulse on each square-wave rising edge |

## Verification
A committed word is visible on the outputs two edges after the low-byte strobe. The commit happens on the first edge, and the first addition with the new step happens on the second. A start enable shows its first accumulated value on the second edge after it is raised. `sq_out` and `tick_out` come from registers updated on that same edge, so neither lags the accumulator. The bench advances a cycle-exact arithmetic model at every rising edge using the inputs it has just driven, then compares both outputs at the following falling edge. Sweeps over every power-of-two step add period-long high-time and tick counts.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = WORD_W / 2;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/nco_word_stage.sv
module nco_word_stage #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned BYTE_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_hi,
    input  logic              wr_lo,
    output logic [WORD_W-1:0] word_q
);
    logic [BYTE_W-1:0] hi_stage_q;

    // Staging register for the upper half; no effect on the live word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
        end else if (wr_hi) begin
            hi_stage_q <= wr_data;
        end
    end

    // The low-half write is the commit point for the whole word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_lo) begin
            word_q <= {hi_stage_q, wr_data};
        end
    end

    // R2: without a low-half write the live word cannot move
    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(word_q));

    // R3: after a commit, the low half equals the byte that was presented
    p_commit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> word_q[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/nco_step_map.sv
module nco_step_map #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] step_o
);
    localparam logic [WORD_W-1:0] HALF = WORD_W'(1) << (WORD_W - 1);

    // Words in the upper half of the range are read as a negative value
    // and folded back to their magnitude.
    always_comb begin
        if (word_i[WORD_W-1]) begin
            step_o = (~word_i) + WORD_W'(1);
        end else begin
            step_o = word_i;
        end
    end

    // R4: the folded step never exceeds half the phase circle
    always_comb begin
        a_step_bound_r4: assert (step_o <= HALF);
    end
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
    import nco_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [WORD_W-1:0] step_i,
    output logic              sq_out,
    output logic              tick_out
);
    run_state_e        state_q, state_d;
    logic [WORD_W-1:0] acc_q, acc_d;
    logic              tick_q;

    // Next-state logic: START and HALT transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (run_en)  state_d = ST_RUNNING; // START
            ST_RUNNING: if (!run_en) state_d = ST_STOPPED; // HALT
            default:                 state_d = ST_STOPPED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // Accumulator next value by state.
    always_comb begin
        acc_d = '0;
        unique case (state_q)
            ST_STOPPED: acc_d = '0;
            ST_RUNNING: acc_d = run_en ? (acc_q + step_i) : '0;
            default:    acc_d = '0;
        endcase
    end

    // Output process: accumulator and rising-edge tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= acc_d[WORD_W-1] & ~acc_q[WORD_W-1];
        end
    end

    assign sq_out   = acc_q[WORD_W-1];
    assign tick_out = tick_q;

    // R5: while running, the phase advances by exactly the step
    p_acc_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && run_en) |=> acc_q == $past(acc_q) + $past(step_i));

    // R6: a tick only accompanies a fresh rise of the square wave
    p_tick_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> (sq_out && !$past(sq_out)));

    // R7: a low enable clears the phase and suppresses ticks
    p_stop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (acc_q == '0 && !tick_out && state_q == ST_STOPPED));

    // R7: the START edge never adds a step
    p_start_from_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |=> acc_q == '0);
endmodule

// File: rtl/nco_rategen.sv
module nco_rategen
    import nco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              run_en,
    output logic              sq_out,
    output logic              tick_out
);
    logic [WORD_W-1:0] word_w;
    logic [WORD_W-1:0] step_w;

    nco_word_stage #(.WORD_W(WORD_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .word_q  (word_w)
    );

    nco_step_map #(.WORD_W(WORD_W)) u_map (
        .word_i (word_w),
        .step_o (step_w)
    );

    nco_phase_core #(.WORD_W(WORD_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .step_i   (step_w),
        .sq_out   (sq_out),
        .tick_out (tick_out)
    );

    // R1: outputs are quiet while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sq_out && !tick_out));
endmodule

// File: tb/nco_rategen_tb_top.sv
module nco_rategen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic       run_en = 1'b0;
    logic       sq_out, tick_out;

    always #2 clk = ~clk; // 250 MHz

    nco_rategen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .run_en(run_en), .sq_out(sq_out), .tick_out(tick_out)
    );

    int total = 0;
    int bad = 0;

    // Bench model state, derived from the requirements.
    int m_running = 0;
    int m_acc = 0;
    int m_word = 0;
    int m_hi = 0;
    int m_sq = 0;
    int m_tick = 0;
    int run_err = 0;
    int run_high = 0;
    int run_ticks = 0;
    int first_act_sq, first_exp_sq, first_act_tk, first_exp_tk;

    function automatic int step_of(int w);
        return (w < 32768) ? w : (65536 - w);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One reference cycle: model update at the edge, compare at the next falling edge.
    task automatic cyc();
        int old_msb, nacc;
        @(posedge clk);
        old_msb = m_acc / 32768;
        if (!rst_n) begin
            nacc = 0; m_running = 0; m_word = 0; m_hi = 0;
        end else begin
            nacc = (m_running != 0 && run_en) ? ((m_acc + step_of(m_word)) % 65536) : 0;
            m_running = run_en ? 1 : 0;
            if (wr_lo) m_word = m_hi * 256 + int'(wr_data);
            if (wr_hi) m_hi = int'(wr_data);
        end
        m_acc = nacc;
        m_sq = m_acc / 32768;
        m_tick = (m_sq == 1 && old_msb == 0) ? 1 : 0;
        @(negedge clk);
        if (int'(sq_out) != m_sq || int'(tick_out) != m_tick) begin
            if (run_err == 0) begin
                first_act_sq = int'(sq_out); first_exp_sq = m_sq;
                first_act_tk = int'(tick_out); first_exp_tk = m_tick;
            end
            run_err++;
        end
        if (sq_out) run_high++;
        if (tick_out) run_ticks++;
    endtask

    task automatic run_n(input int n, input string req);
        run_err = 0; run_high = 0; run_ticks = 0;
        for (int i = 0; i < n; i++) cyc();
        check(run_err == 0, req, "cycle mismatches (first sq act/exp, tick act/exp)",
              first_act_sq * 10 + first_act_tk, first_exp_sq * 10 + first_exp_tk);
    endtask

    task automatic load_word(input int w);
        wr_data = 8'((w >> 8) & 255); wr_hi = 1'b1; cyc(); wr_hi = 1'b0;
        wr_data = 8'(w & 255);        wr_lo = 1'b1; cyc(); wr_lo = 1'b0;
    endtask

    task automatic stop_run();
        run_en = 1'b0; cyc();
    endtask

    initial begin
        int words[6];
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        // R1: reset state
        check(sq_out == 1'b0 && tick_out == 1'b0, "R1", "outputs in reset",
              int'(sq_out) + int'(tick_out), 0);
        rst_n = 1'b1;
        cyc();
        check(sq_out == 1'b0 && tick_out == 1'b0, "R1", "outputs after reset",
              int'(sq_out) + int'(tick_out), 0);

        // R9: word left at reset value 0x0000 gives no output while running
        run_en = 1'b1;
        run_n(200, "R9");
        check(run_high == 0 && run_ticks == 0, "R9", "zero step activity",
              run_high + run_ticks, 0);
        stop_run();

        // R4 R5 R6: assorted words, including folded ones, cycle-exact
        words = '{16'h0003, 16'h1234, 16'hFFFF, 16'h8001, 16'hC000, 16'h8000};
        foreach (words[j]) begin
            load_word(words[j]);
            run_en = 1'b1;
            run_n(700, "R4/R5/R6 assorted word");
            stop_run();
        end

        // R7: first edge with enable high only starts; stopping clears
        load_word(16'h4000);
        run_en = 1'b1;
        cyc();
        check(sq_out == 1'b0, "R7", "sq after START edge", int'(sq_out), 0);
        cyc(); cyc();
        check(sq_out == 1'b1 && tick_out == 1'b1, "R7", "rise on second accumulate",
              int'(sq_out) * 10 + int'(tick_out), 11);
        run_en = 1'b0;
        run_n(20, "R7");
        check(run_high == 0 && run_ticks == 0, "R7", "stopped activity",
              run_high + run_ticks, 0);

        // R2: high-byte write alone while running keeps the old step
        load_word(16'h1000);
        run_en = 1'b1;
        run_n(37, "R2 before");
        wr_data = 8'h7F; wr_hi = 1'b1; cyc(); wr_hi = 1'b0;
        run_n(300, "R2");

        // R3: low-byte write commits, using the previously staged high byte
        wr_data = 8'h05; wr_hi = 1'b1; cyc(); wr_hi = 1'b0;
        wr_data = 8'h22; wr_hi = 1'b1; wr_lo = 1'b1; cyc();
        wr_hi = 1'b0; wr_lo = 1'b0;
        check(m_word == 16'h0522, "R3", "model commit word", m_word, 16'h0522);
        run_n(400, "R3 same-cycle commit");
        // staged 0x22 then commit with a plain low write, mid-run
        wr_data = 8'h80; wr_lo = 1'b1; cyc(); wr_lo = 1'b0;
        run_n(400, "R3 mid-run commit");
        stop_run();

        // R8: sweep all power-of-two steps, one full period each
        for (int k = 1; k <= 15; k++) begin
            int per;
            per = 65536 >> k;
            load_word(1 << k);
            run_en = 1'b1;
            cyc(); // START edge
            run_n(per, "R8 power-of-two period");
            check(run_high == per / 2, "R8", $sformatf("high time k=%0d", k), run_high, per / 2);
            check(run_ticks == 1, "R8", $sformatf("ticks per period k=%0d", k), run_ticks, 1);
            stop_run();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule